// File: doc/BRIEF.md
# Sigma-Delta Pulse Density Modulator

This block converts an unsigned input level into a one-bit stream whose density of ones is the level divided by a modulus. A first-order sigma-delta accumulator produces it. Each enabled clock cycle the accumulator is compared with the modulus. When it has reached the modulus, the modulus is subtracted, the level is added and a one is emitted. Otherwise only the level is added and a zero is emitted. The ones are spread evenly across the period rather than gathered into one wide pulse. An external low-pass filter therefore sees the same average with far less ripple than a counter-compare PWM would give.

The modulus can be any value, not only a power of two, so the density is an exact ratio. A companion pulse output fires once per subtraction on enabled cycles only. Used on its own, that pulse turns the block into a level-to-frequency converter: the pulse rate is the clock rate times level over modulus. The modulus port is captured only while reset is asserted, so a new modulus always starts from a cleared accumulator.

Top module: `pdm_modulator_top`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator clears to 0 and both `pdm_out` and `pulse_out` read 0 after that edge.
- R2: On an enabled edge where the accumulator is at or above the captured modulus, `pdm_out` becomes 1 and the accumulator becomes accumulator minus modulus plus level.
- R3: On an enabled edge where the accumulator is below the captured modulus, `pdm_out` becomes 0 and the accumulator becomes accumulator plus level.
- R4: The level is held constant with 0 <= level <= modulus. After one enabled cycle at that level, every run of `modulus` consecutive enabled cycles carries exactly `level` ones on `pdm_out`.
- R5: A level equal to the modulus gives a constant 1 once settled. A level of 0 gives a constant 0 once the accumulator has drained below the modulus.
- R6: On an edge with `en` low and `rst` low, the accumulator and `pdm_out` keep their values.
- R7: `pulse_out` is 1 for exactly the cycle following each enabled edge that takes the subtract branch, and is 0 after any edge with `en` low.
- R8: `modulus_in` is captured only on edges where `rst` is high. Changing it at any other time has no effect on the output stream.
- R9: When `rst` and `en` are both high on the same edge, the reset takes effect and no accumulation happens.
- R10: For a captured modulus of at least 1 and a legal level, the accumulator always stays below twice the modulus and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the modulus |
| en | input | 1 | Advance the modulator on this edge |
| level_in | input | DATA_W | Unsigned input level, 0..modulus |
| modulus_in | input | MOD_W | Modulus, sampled only during reset, at least 1 |
| pdm_out | output | 1 | Pulse-density stream |
| pulse_out | output | 1 | One-cycle pulse per subtraction (level-to-frequency output) |

## Verification
Reset and enable can fall on the same edge. At that moment the accumulator may also be about to take the subtract branch. The bench raises `rst` together with `en` while a one is due, then checks that `pdm_out` and `pulse_out` both read 0 after that edge. It also checks that the next enabled cycles follow a cleared accumulator and the newly captured modulus. A second overlap is an enable-low edge that comes right after a subtraction. There, `pdm_out` must hold its 1 while `pulse_out` drops, and every cycle is compared against a reference model of the recurrence.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    // Branch taken by the modulator on an enabled edge.
    typedef enum logic {
        STEP_ADD = 1'b0,
        STEP_SUB = 1'b1
    } step_e;

    // Output level held while in reset.
    localparam logic IDLE_LEVEL = 1'b0;

    // Accumulator needs one extra bit above the modulus width:
    // the value stays below twice the modulus.
    function automatic int acc_width(input int mod_w);
        return mod_w + 1;
    endfunction

    // Branch selection from accumulator versus modulus.
    function automatic step_e pick_step(input logic ge);
        return ge ? STEP_SUB : STEP_ADD;
    endfunction

endpackage

// File: rtl/pdm_modulus_reg.sv
module pdm_modulus_reg #(
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MOD_W-1:0] modulus_in,
    output logic [MOD_W-1:0] modulus_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            modulus_q <= modulus_in;
        end
    end

    // Captured modulus only moves while reset is asserted.
    assert_mod_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(modulus_q));

endmodule

// File: rtl/pdm_accum.sv
module pdm_accum
    import pdm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MOD_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] level_in,
    input  logic [MOD_W-1:0]  modulus_q,
    output logic              bit_q,
    output step_e             step
);

    localparam int AW = acc_width(MOD_W);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          bit_v;
    } mod_state_t;

    mod_state_t    cur, nxt;
    logic [AW-1:0] level_ext;
    logic [AW-1:0] mod_ext;

    assign level_ext = AW'(level_in);
    assign mod_ext   = AW'(modulus_q);
    assign step      = pick_step(cur.acc >= mod_ext);

    always_comb begin
        nxt = cur;
        if (en) begin
            unique case (step)
                STEP_SUB: begin
                    nxt.acc   = cur.acc - mod_ext + level_ext;
                    nxt.bit_v = 1'b1;
                end
                default: begin
                    nxt.acc   = cur.acc + level_ext;
                    nxt.bit_v = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.acc   <= '0;
            cur.bit_v <= IDLE_LEVEL;
        end else begin
            cur <= nxt;
        end
    end

    assign bit_q = cur.bit_v;

    initial begin
        assert (DATA_W <= MOD_W);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cur.acc == '0 && bit_q == 1'b0));

    assert_sub_one_R2: assert property (@(posedge clk) disable iff (rst)
        (en && cur.acc >= mod_ext) |=> bit_q);

    assert_add_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (en && cur.acc < mod_ext) |=> !bit_q);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cur.acc) && $stable(bit_q)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (modulus_q != '0 && AW'(level_in) <= mod_ext) |-> (cur.acc < (mod_ext << 1)));

endmodule

// File: rtl/pdm_pulse_gen.sv
module pdm_pulse_gen
    import pdm_pkg::*;
#(
    parameter bit PULSE_EN = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  step_e step,
    output logic  pulse_q
);

    generate
        if (PULSE_EN) begin : g_pulse
            logic fire_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    fire_q <= 1'b0;
                end else begin
                    fire_q <= en && (step == STEP_SUB);
                end
            end
            assign pulse_q = fire_q;

            assert_pulse_on_sub_R7: assert property (@(posedge clk) disable iff (rst)
                (en && step == STEP_SUB) |=> pulse_q);
            assert_pulse_idle_R7: assert property (@(posedge clk) disable iff (rst)
                !en |=> !pulse_q);
        end else begin : g_no_pulse
            assign pulse_q = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pdm_modulator_top.sv
module pdm_modulator_top
    import pdm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MOD_W    = 8,
    parameter bit PULSE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] level_in,
    input  logic [MOD_W-1:0]  modulus_in,
    output logic              pdm_out,
    output logic              pulse_out
);

    logic [MOD_W-1:0] modulus_q;
    step_e            step;

    pdm_modulus_reg #(.MOD_W(MOD_W)) u_modreg (
        .clk        (clk),
        .rst        (rst),
        .modulus_in (modulus_in),
        .modulus_q  (modulus_q)
    );

    pdm_accum #(.DATA_W(DATA_W), .MOD_W(MOD_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .level_in  (level_in),
        .modulus_q (modulus_q),
        .bit_q     (pdm_out),
        .step      (step)
    );

    pdm_pulse_gen #(.PULSE_EN(PULSE_EN)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .step    (step),
        .pulse_q (pulse_out)
    );

    // Reset overriding a simultaneous enable.
    assert_reset_wins_R9: assert property (@(posedge clk)
        (rst && en) |=> (!pdm_out && !pulse_out));

endmodule

// File: tb/pdm_modulator_top_tb_top.sv
`timescale 1ns/1ps
module pdm_modulator_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] level_in   = 8'd0;
    logic [7:0] modulus_in = 8'd1;
    logic       pdm_out;
    logic       pulse_out;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    int m_mod = 1;
    int m_acc = 0;
    int m_out = 0;
    int m_pul = 0;

    always #5 clk = ~clk;

    pdm_modulator_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .level_in   (level_in),
        .modulus_in (modulus_in),
        .pdm_out    (pdm_out),
        .pulse_out  (pulse_out)
    );

    function automatic void chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endfunction

    function automatic void model_edge(input bit r, input bit e, input int x, input int mi);
        if (r) begin
            m_acc = 0; m_out = 0; m_pul = 0; m_mod = mi;
        end else if (e) begin
            if (m_acc >= m_mod) begin
                m_acc = m_acc - m_mod + x; m_out = 1; m_pul = 1;
            end else begin
                m_acc = m_acc + x; m_out = 0; m_pul = 0;
            end
        end else begin
            m_pul = 0;
        end
    endfunction

    // Drive at negedge, clock, then sample at the next negedge.
    task automatic tick(input bit r, input bit e, input int x, input int mi, input string req);
        rst = r; en = e; level_in = 8'(x); modulus_in = 8'(mi);
        @(posedge clk);
        model_edge(r, e, x, mi);
        @(negedge clk);
        chk(pdm_out == m_out[0], req, int'(pdm_out), m_out);
        chk(pulse_out == m_pul[0], req, int'(pulse_out), m_pul);
    endtask

    // Ones count over one full modulus window at a constant level.
    task automatic window(input int x, input int m, input string req);
        int ones = 0;
        tick(0, 1, x, m, req);
        for (int i = 0; i < m; i++) begin
            tick(0, 1, x, (i * 37) & 255, req);
            ones += int'(pdm_out);
        end
        chk(ones == x, req, ones, x);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        @(negedge clk);

        // R1: reset state
        tick(1, 0, 0, 10, "R1");
        tick(1, 0, 0, 10, "R1");
        chk(pdm_out == 1'b0 && pulse_out == 1'b0, "R1", int'(pdm_out), 0);

        // R2/R3 step sequence M=10, x=3
        for (int i = 0; i < 12; i++) tick(0, 1, 3, 10, "R2 R3");

        // R4 density windows, R8 modulus_in wiggled inside window
        window(3, 10, "R4 R8");
        window(7, 10, "R4");
        tick(1, 0, 0, 13, "R1");
        window(5, 13, "R4");
        window(12, 13, "R4");
        tick(1, 0, 0, 255, "R1");
        window(200, 255, "R4");

        // R5 full scale and drain to zero
        tick(1, 0, 0, 9, "R1");
        tick(0, 1, 9, 9, "R5");
        for (int i = 0; i < 20; i++) begin
            tick(0, 1, 9, 9, "R5");
            chk(pdm_out == 1'b1, "R5", int'(pdm_out), 1);
        end
        tick(0, 1, 0, 9, "R5");
        tick(0, 1, 0, 9, "R5");
        for (int i = 0; i < 20; i++) begin
            tick(0, 1, 0, 9, "R5");
            chk(pdm_out == 1'b0, "R5", int'(pdm_out), 0);
        end

        // R6/R7 pause right after a one: output holds, pulse drops
        tick(1, 0, 0, 4, "R1");
        tick(0, 1, 3, 4, "R7");
        while (!(pdm_out == 1'b1)) tick(0, 1, 3, 4, "R7");
        for (int i = 0; i < 5; i++) begin
            tick(0, 0, 1, 4, "R6 R7");
            chk(pdm_out == 1'b1 && pulse_out == 1'b0, "R6", int'(pdm_out), 1);
        end
        for (int i = 0; i < 8; i++) tick(0, 1, 3, 4, "R6");

        // R9 reset and enable together while a one is due
        tick(1, 0, 0, 2, "R1");
        tick(0, 1, 2, 2, "R9");
        tick(0, 1, 2, 2, "R9");
        tick(1, 1, 2, 6, "R9");
        chk(pdm_out == 1'b0 && pulse_out == 1'b0, "R9", int'(pdm_out), 0);
        tick(0, 1, 5, 0, "R9 R8");
        chk(pdm_out == 1'b0, "R9", int'(pdm_out), 0);

        // Constrained random epochs (R2 R3 R6 R7 R8 R10)
        for (int ep = 0; ep < 40; ep++) begin
            int m = 1 + int'($urandom_range(254));
            tick(1, int'($urandom_range(1)), 0, m, "R1");
            for (int c = 0; c < 400; c++) begin
                int x = int'($urandom_range(m));
                bit e = ($urandom_range(9) < 8);
                tick(0, e, x, int'($urandom_range(255)), "R2 R3 R6 R7 R8");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule